// File: doc/BRIEF.md
# Software Write-Protection Sequence Detector

This block sits on the write path of a byte-wide non-volatile memory, between the logic that captures each write strobe and the controller that programs the array. Every captured address/data pair is offered to it for one clock with `wr_valid`. It compares the pair against two fixed command codes and answers with a one-cycle qualifier, `allow_o`, that says whether the pair may go on to the array. It also reports the protection mode bit, `prot_o`, which reset clears.

A three-write arming prefix puts the block into the protected mode, but only when a fourth write follows it. That fourth write is an ordinary data write and is stored. Once protection is on, the array takes a write only if the full arming prefix comes straight before it. A separate six-write release code turns protection off. The command writes of both codes are never passed on to the array. The write-strobe logic raises `win_expire` when the byte-load window after a write has run out. This throws away any partly matched code.

The address comparison looks only at the low `CMP_W` bits. With the default of 15 bits, the two alternative addresses of the second and fifth steps fall on the same pattern, 0x2AAA. Bits above those are ignored.

Top module: `wp_seq_guard`

## Requirements
- R1: While reset is high and in the first cycle after it, `allow_o` and `prot_o` are both 0.
- R2: With protection off, a write that does not continue a code, and does not begin one, raises `allow_o` for exactly the cycle after its `wr_valid`.
- R3: Writes consumed as command steps never raise `allow_o`. The steps are: address low bits 0x5555 with data 0xAA; 0x2AAA with 0x55; 0x5555 with 0xA0, 0x80 or 0x20, each in its place in a code.
- R4: The arming prefix is 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0, each matched on address bits [14:0] only. The write that follows it raises `allow_o`, and `prot_o` becomes 1 in that same cycle.
- R5: If the window expires after the arming prefix and before the fourth write, protection stays off, and the next write is judged as a plain write.
- R6: With protection on, a write not directly preceded by the full arming prefix never raises `allow_o`.
- R7: With protection on, the arming prefix followed by a write raises `allow_o`, and `prot_o` stays 1.
- R8: The release code is 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. Completing it clears `prot_o` in the cycle after its last write, and none of its six writes raises `allow_o`.
- R9: A `win_expire` pulse returns a partly matched code to idle. A following write that would have continued the code is then judged on its own.
- R10: A write that breaks a partial code returns the matcher to idle and is judged as a plain write. If that write is itself 0x5555/0xAA, it starts a new code.
- R11: When `win_expire` and `wr_valid` arrive in the same cycle, the write is judged as if the matcher were already idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle pulse marking a captured write |
| wr_addr | input | ADDR_W | Captured write address |
| wr_data | input | DATA_W | Captured write data |
| win_expire | input | 1 | Pulse: byte-load window after the last write has run out |
| allow_o | output | 1 | Registered: previous write may go to the array |
| prot_o | output | 1 | Registered protection mode bit |

## Verification
The codes are driven both unbroken and cut short, in each protection mode. Cutting a code short shows whether the matcher really requires consecutive steps or only counts matching bytes. Upper address bits are varied, and both an expiry and a mismatching write are placed at several depths of each code. These patterns separate correct step tracking from a matcher that ignores the window or forgets to restart. A write that lands in the same cycle as an expiry, and command bytes sent to the wrong addresses, check the priority between timeout and match and the address and data compare on its own.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

  // Matcher progress through the two command codes
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // nothing matched
    ST_P1   = 3'd1,  // first step (shared by both codes) seen
    ST_P2   = 3'd2,  // second step (shared) seen
    ST_ARM  = 3'd3,  // arming prefix complete, next write is data
    ST_D3   = 3'd4,  // release code: third step seen
    ST_D4   = 3'd5,  // release code: fourth step seen
    ST_D5   = 3'd6   // release code: fifth step seen
  } seq_st_t;

  // Command data bytes
  localparam logic [7:0] K_LEAD  = 8'hAA;
  localparam logic [7:0] K_MID   = 8'h55;
  localparam logic [7:0] K_ARM   = 8'hA0;
  localparam logic [7:0] K_REL   = 8'h80;
  localparam logic [7:0] K_FINAL = 8'h20;

  // Per-write verdict from the matcher
  typedef struct packed {
    logic take;    // write consumed as a command step
    logic plain;   // ordinary write, subject to the mode bit
    logic arm_wr;  // data write that follows a full arming prefix
    logic clr;     // release code completed
  } seq_evt_t;

endpackage

// File: rtl/wpd_addr_match.sv
module wpd_addr_match #(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = 15
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              at_lo,  // low bits equal alternating pattern with bit 0 set
  output logic              at_hi   // low bits equal alternating pattern with bit 0 clear
);
  logic [CMP_W-1:0] pat_even;
  logic [CMP_W-1:0] pat_odd;

  for (genvar i = 0; i < CMP_W; i++) begin : g_pat
    assign pat_even[i] = ((i % 2) == 0);
    assign pat_odd[i]  = ((i % 2) == 1);
  end

  assign at_lo = (addr[CMP_W-1:0] == pat_even);
  assign at_hi = (addr[CMP_W-1:0] == pat_odd);

  if (ADDR_W > CMP_W) begin : g_hi_bits
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:CMP_W];
  end
endmodule

// File: rtl/wpd_seq_fsm.sv
module wpd_seq_fsm
  import wpd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              expire,
  input  logic              at_lo,
  input  logic              at_hi,
  input  logic [DATA_W-1:0] data,
  output seq_evt_t          evt
);
  seq_st_t st_q, st_d, st_eff;

  logic h_lead, h_mid, h_arm, h_rel, h_fin;
  assign h_lead = at_lo && (data == DATA_W'(K_LEAD));
  assign h_mid  = at_hi && (data == DATA_W'(K_MID));
  assign h_arm  = at_lo && (data == DATA_W'(K_ARM));
  assign h_rel  = at_lo && (data == DATA_W'(K_REL));
  assign h_fin  = at_lo && (data == DATA_W'(K_FINAL));

  // An expiry in the same cycle as a write acts first
  assign st_eff = expire ? ST_IDLE : st_q;

  always_comb begin
    st_d = st_eff;
    evt  = '0;
    if (valid) begin
      unique case (st_eff)
        ST_ARM: begin
          evt.arm_wr = 1'b1;
          st_d       = ST_IDLE;
        end
        ST_IDLE, ST_D3: begin
          if (h_lead) begin
            evt.take = 1'b1;
            st_d     = (st_eff == ST_D3) ? ST_D4 : ST_P1;
          end else begin
            evt.plain = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        ST_P1, ST_D4: begin
          if (h_mid) begin
            evt.take = 1'b1;
            st_d     = (st_eff == ST_D4) ? ST_D5 : ST_P2;
          end else if (h_lead) begin
            evt.take = 1'b1;
            st_d     = ST_P1;
          end else begin
            evt.plain = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        ST_P2: begin
          if (h_arm) begin
            evt.take = 1'b1;
            st_d     = ST_ARM;
          end else if (h_rel) begin
            evt.take = 1'b1;
            st_d     = ST_D3;
          end else if (h_lead) begin
            evt.take = 1'b1;
            st_d     = ST_P1;
          end else begin
            evt.plain = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        ST_D5: begin
          if (h_fin) begin
            evt.take = 1'b1;
            evt.clr  = 1'b1;
            st_d     = ST_IDLE;
          end else if (h_lead) begin
            evt.take = 1'b1;
            st_d     = ST_P1;
          end else begin
            evt.plain = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        default: begin
          evt.plain = 1'b1;
          st_d      = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/wpd_prot_gate.sv
module wpd_prot_gate
  import wpd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  seq_evt_t evt,
  output logic     allow_q,
  output logic     prot_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      allow_q <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      allow_q <= evt.arm_wr || (evt.plain && !prot_q);
      if (evt.arm_wr)   prot_q <= 1'b1;
      else if (evt.clr) prot_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wpd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_expire,
  output logic              allow_o,
  output logic              prot_o
);
  logic     at_lo, at_hi;
  seq_evt_t evt;
  logic     evt_take, evt_arm;

  wpd_addr_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
    .addr  (wr_addr),
    .at_lo (at_lo),
    .at_hi (at_hi)
  );

  wpd_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .valid  (wr_valid),
    .expire (win_expire),
    .at_lo  (at_lo),
    .at_hi  (at_hi),
    .data   (wr_data),
    .evt    (evt)
  );

  wpd_prot_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .allow_q (allow_o),
    .prot_q  (prot_o)
  );

  assign evt_take = evt.take;
  assign evt_arm  = evt.arm_wr;
endmodule

// File: rtl/wpd_chk.sv
module wpd_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              allow_o,
  input logic              prot_o,
  input logic              evt_take,
  input logic              evt_arm
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!allow_o && !prot_o));

  // R2
  allow_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    allow_o |-> $past(wr_valid));

  // R3
  cmd_not_stored_chk: assert property (@(posedge clk) disable iff (rst)
    allow_o |-> !$past(evt_take));

  // R4
  prot_rise_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_o) |-> allow_o);

  // R6
  protected_needs_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (allow_o && $past(prot_o)) |-> $past(evt_arm));

  // R8
  prot_fall_on_final_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(prot_o) && !$past(rst)) |->
      ($past(wr_valid) && ($past(wr_data) == DATA_W'(8'h20)) && !allow_o));
endmodule

bind wp_seq_guard wpd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_data  (wr_data),
  .allow_o  (allow_o),
  .prot_o   (prot_o),
  .evt_take (evt_take),
  .evt_arm  (evt_arm)
);

// File: tb/wp_seq_guard_tb.sv
module wp_seq_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        win_expire = 1'b0;
  logic        allow_o, prot_o;

  int checks = 0;
  int errors = 0;

  // Behavioural model state
  int hq[$];
  int cand[$];
  int en_seq[3]  = '{'h1AA, 'h255, 'h1A0};
  int rel_seq[6] = '{'h1AA, 'h255, 'h180, 'h1AA, 'h255, 'h120};
  bit m_allow = 1'b0;
  bit m_prot  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_seq_guard u_dut (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .win_expire (win_expire),
    .allow_o    (allow_o),
    .prot_o     (prot_o)
  );

  function automatic int addr_kind(logic [16:0] a);
    if (a[14:0] == 15'h5555) return 1;
    if (a[14:0] == 15'h2AAA) return 2;
    return 0;
  endfunction

  function automatic bit cand_on_path();
    bit ok_en, ok_rel;
    ok_en  = (cand.size() <= 3);
    ok_rel = (cand.size() <= 6);
    for (int i = 0; i < cand.size(); i++) begin
      if (i < 3 && cand[i] != en_seq[i]) ok_en = 1'b0;
      if (i < 6 && cand[i] != rel_seq[i]) ok_rel = 1'b0;
    end
    return ok_en || ok_rel;
  endfunction

  task automatic model_step(bit v, logic [16:0] a, logic [7:0] d, bit e);
    int code;
    if (e) hq.delete();
    m_allow = 1'b0;
    if (v) begin
      code = addr_kind(a) * 256 + int'(d);
      if (hq.size() == 3 && hq[2] == en_seq[2]) begin
        m_allow = 1'b1;
        m_prot  = 1'b1;
        hq.delete();
      end else begin
        cand = hq;
        cand.push_back(code);
        if (cand_on_path()) begin
          hq = cand;
          if (hq.size() == 6) begin
            m_prot = 1'b0;
            hq.delete();
          end
        end else if (code == en_seq[0]) begin
          hq.delete();
          hq.push_back(code);
        end else begin
          hq.delete();
          m_allow = !m_prot;
        end
      end
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (allow_o !== m_allow || prot_o !== m_prot) begin
      errors++;
      $display("FAIL %s: allow=%0b prot=%0b expected allow=%0b prot=%0b at %0t",
               tag, allow_o, prot_o, m_allow, m_prot, $time);
    end
  endtask

  // Drive at a falling edge, compare at the next falling edge
  task automatic cyc(bit v, logic [16:0] a, logic [7:0] d, bit e, string tag);
    wr_valid   = v;
    wr_addr    = a;
    wr_data    = d;
    win_expire = e;
    model_step(v, a, d, e);
    @(negedge clk);
    check(tag);
  endtask

  task automatic wr(logic [16:0] a, logic [7:0] d, string tag);
    cyc(1'b1, a, d, 1'b0, tag);
    cyc(1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic expire_pulse(string tag);
    cyc(1'b0, '0, '0, 1'b1, tag);
  endtask

  task automatic arm_prefix(logic [16:0] second, string tag);
    wr(17'h05555, 8'hAA, tag);
    wr(second,    8'h55, tag);
    wr(17'h15555, 8'hA0, tag);
  endtask

  task automatic release_code(string tag);
    wr(17'h05555, 8'hAA, tag);
    wr(17'h0AAAA, 8'h55, tag);
    wr(17'h05555, 8'h80, tag);
    wr(17'h05555, 8'hAA, tag);
    wr(17'h02AAA, 8'h55, tag);
    wr(17'h05555, 8'h20, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1");          // during reset
    rst = 1'b0;
    @(negedge clk);
    check("R1");          // first cycle after reset

    // R2: plain writes, including near-misses of command bytes
    wr(17'h01234, 8'h5A, "R2");
    wr(17'h15555, 8'h33, "R2");
    wr(17'h00000, 8'hAA, "R2");
    wr(17'h02AAA, 8'h55, "R2");

    // R3 / R4: arming prefix (upper bits set, AAAA form), then data
    wr(17'h1D555, 8'hAA, "R3");
    wr(17'h0AAAA, 8'h55, "R3");
    wr(17'h05555, 8'hA0, "R3");
    wr(17'h00100, 8'hC3, "R4");

    // R6: protected, plain writes refused
    wr(17'h00100, 8'h11, "R6");
    wr(17'h05555, 8'h33, "R6");
    wr(17'h02AAA, 8'h55, "R6");

    // R7: protected, prefix with 2AAA form, then data write accepted
    arm_prefix(17'h02AAA, "R7");
    wr(17'h05555, 8'hAA, "R7");   // data equal to a command byte is still data
    wr(17'h00400, 8'h99, "R6");

    // R8: release code
    release_code("R8");
    wr(17'h00123, 8'h7E, "R2");

    // R5: prefix then expiry does not arm
    arm_prefix(17'h0AAAA, "R5");
    expire_pulse("R5");
    wr(17'h00200, 8'h11, "R5");
    wr(17'h00201, 8'h12, "R5");

    // R9: expiry mid-code, continuation judged alone
    wr(17'h05555, 8'hAA, "R9");
    wr(17'h0AAAA, 8'h55, "R9");
    expire_pulse("R9");
    wr(17'h05555, 8'hA0, "R9");

    // R10: mismatch restarts, repeated lead byte restarts
    wr(17'h05555, 8'hAA, "R10");
    wr(17'h01234, 8'h77, "R10");
    wr(17'h05555, 8'hAA, "R10");
    wr(17'h05555, 8'hAA, "R10");
    wr(17'h0AAAA, 8'h55, "R10");
    wr(17'h05555, 8'hA0, "R10");
    wr(17'h00300, 8'h5C, "R10");
    wr(17'h05555, 8'hAA, "R10");
    wr(17'h02AAA, 8'h55, "R10");
    wr(17'h00301, 8'h01, "R10");  // protected, broken code refused

    // R11: expiry and write together after a full prefix
    arm_prefix(17'h0AAAA, "R11");
    cyc(1'b1, 17'h00302, 8'h44, 1'b1, "R11");
    cyc(1'b0, '0, '0, 1'b0, "R11");

    // R8: release broken at the last step keeps protection
    wr(17'h05555, 8'hAA, "R8");
    wr(17'h0AAAA, 8'h55, "R8");
    wr(17'h05555, 8'h80, "R8");
    wr(17'h05555, 8'hAA, "R8");
    wr(17'h0AAAA, 8'h55, "R8");
    wr(17'h05555, 8'h21, "R8");
    release_code("R8");
    wr(17'h00500, 8'h0F, "R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule